// File: doc/BRIEF.md
# Register Burst Access Sequencer

This block sits between a bus master and a small peripheral register file. It makes one window address act as a pointer that advances by itself. Software or a DMA engine writes a control register with two 5-bit fields: a starting register index and a length code. After that, each access to the window address is sent to the register at the starting index plus the current burst position. The position then advances, and it returns to zero once the programmed number of transfers has completed. A DMA engine can therefore move a block of consecutive registers by reading or writing one fixed address again and again.

Addresses other than the control and window addresses go straight to the register file. Each outstanding transfer raises a request line, which lets a simple DMA engine pace itself. Indices start at register 0 of the file. A burst that runs past the last implemented register is made harmless: reads return zero and writes are dropped.

Top module: `burst_seq`

## Requirements
- R1: After a synchronous reset, the control register reads 0 and `xfer_req` is low. A window access is then directed to register index 0.
- R2: On a read, the control register returns the start index in bits [4:0] and the length code in bits [12:8]. All other bits read as zero, even if ones were written to them.
- R3: A window access (address `WIN_ADDR`) drives `reg_idx` = start index + position and passes `bus_write` and `bus_wdata` through to the register-file port in the same cycle.
- R4: The position advances by one after each window access. It returns to 0 after the access that completes a burst of code+1 transfers.
- R5: Length codes above 17 give bursts of 18 transfers.
- R6: A write to the control register sets the position to 0.
- R7: If the target index is at or beyond `NUM_REGS`, `reg_valid` stays low and a window read returns 0.
- R8: `xfer_req` rises in the cycle after a control write. It is low in the cycle after each window access. It rises again in the following cycle while transfers remain, and it stays low once the last transfer of the burst has been made.
- R9: An access to any address below `NUM_REGS` goes to that same index and leaves the position unchanged.
- R10: A window read returns the `reg_rdata` of the target register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address on the bus |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| reg_valid | output | 1 | Access strobe to the register file |
| reg_write | output | 1 | Write enable to the register file |
| reg_idx | output | IW | Target register index |
| reg_wdata | output | DW | Write data to the register file |
| reg_rdata | input | DW | Combinational read data from the register file |
| xfer_req | output | 1 | Transfer request, one pulse per outstanding transfer |

## Verification
The bench targets the last transfer of a burst. A counter with an off-by-one would either reach one register too many or wrap one access early, and `xfer_req` would then rise again after the burst had ended. Oversized length codes are tested at the clamp boundary, where a design without the clamp would run 32 transfers. Bursts that cross the end of the register file are tested as well: there a missing range check would reach an alias of a low register through the truncated index. The bench also tests a control write in the middle of a burst and direct accesses placed between window accesses. These expose a position that fails to clear on the control write, or one that advances on accesses that are not window accesses.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int FLD_W    = 5;
    localparam int MAX_CODE = 17;
    localparam int BASE_LSB = 0;
    localparam int LEN_LSB  = 8;

    typedef struct packed {
        logic [FLD_W-1:0] len_code;
        logic [FLD_W-1:0] base;
    } burst_cfg_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_WIN,
        ACC_DIRECT
    } acc_kind_e;

    // Transfers in a burst for a given length code, clamped to MAX_CODE+1.
    function automatic logic [FLD_W:0] eff_len(input logic [FLD_W-1:0] code);
        logic [FLD_W-1:0] c;
        c = (code > FLD_W'(MAX_CODE)) ? FLD_W'(MAX_CODE) : code;
        return {1'b0, c} + 1'b1;
    endfunction

endpackage

// File: rtl/burst_ctrl_reg.sv
module burst_ctrl_reg
    import burst_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output burst_cfg_t       cfg,
    output logic [DW-1:0]    rd_val
);

    burst_cfg_t cfg_q;
    logic       unused_rsvd;

    assign unused_rsvd = ^{wdata[DW-1:LEN_LSB+FLD_W], wdata[LEN_LSB-1:BASE_LSB+FLD_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.base     <= wdata[BASE_LSB +: FLD_W];
            cfg_q.len_code <= wdata[LEN_LSB  +: FLD_W];
        end
    end

    always_comb begin
        rd_val = '0;
        rd_val[BASE_LSB +: FLD_W] = cfg_q.base;
        rd_val[LEN_LSB  +: FLD_W] = cfg_q.len_code;
    end

    assign cfg = cfg_q;

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg.base == $past(wdata[BASE_LSB +: FLD_W]) &&
                   cfg.len_code == $past(wdata[LEN_LSB +: FLD_W])));

endmodule

// File: rtl/burst_pos_counter.sv
module burst_pos_counter
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             win_acc,
    input  logic [FLD_W-1:0] len_code,
    output logic [FLD_W-1:0] pos,
    output logic             xfer_req
);

    logic [FLD_W-1:0] pos_q;
    logic             active_q;
    logic             req_q;
    logic             last;

    assign last = ({1'b0, pos_q} == (eff_len(len_code) - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            active_q <= 1'b0;
            req_q    <= 1'b0;
        end else if (cfg_wr) begin
            pos_q    <= '0;
            active_q <= 1'b1;
            req_q    <= 1'b1;
        end else if (win_acc) begin
            pos_q    <= last ? '0 : pos_q + 1'b1;
            active_q <= active_q & ~last;
            req_q    <= 1'b0;
        end else begin
            req_q    <= active_q;
        end
    end

    assign pos      = pos_q;
    assign xfer_req = req_q;

    // R4
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, pos} < eff_len(len_code));

    // R6
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (pos == '0 && xfer_req));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        win_acc |=> !xfer_req);

    // R8
    req_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !xfer_req);

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
#(
    parameter int AW        = 6,
    parameter int IW        = 5,
    parameter int NUM_REGS  = 20,
    parameter int CTRL_ADDR = 20,
    parameter int WIN_ADDR  = 21
) (
    input  logic             bus_valid,
    input  logic [AW-1:0]    bus_addr,
    input  logic [FLD_W-1:0] base,
    input  logic [FLD_W-1:0] pos,
    output acc_kind_e        kind,
    output logic             tgt_ok,
    output logic [IW-1:0]    tgt_idx
);

    localparam int TW = (AW > FLD_W + 1) ? AW : FLD_W + 1;

    logic [TW-1:0] tgt;

    always_comb begin
        kind = ACC_NONE;
        tgt  = '0;
        if (bus_valid) begin
            if (bus_addr == AW'(CTRL_ADDR)) begin
                kind = ACC_CTRL;
            end else if (bus_addr == AW'(WIN_ADDR)) begin
                kind = ACC_WIN;
                tgt  = TW'(base) + TW'(pos);
            end else begin
                kind = ACC_DIRECT;
                tgt  = TW'(bus_addr);
            end
        end
    end

    assign tgt_ok  = (kind == ACC_WIN || kind == ACC_DIRECT) && (tgt < TW'(NUM_REGS));
    assign tgt_idx = tgt[IW-1:0];

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 6,
    parameter int NUM_REGS  = 20,
    parameter int CTRL_ADDR = 20,
    parameter int WIN_ADDR  = 21,
    localparam int IW       = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          reg_valid,
    output logic          reg_write,
    output logic [IW-1:0] reg_idx,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    output logic          xfer_req
);

    burst_cfg_t       cfg;
    logic [DW-1:0]    ctrl_rd;
    logic [FLD_W-1:0] pos;
    acc_kind_e        kind;
    logic             tgt_ok;
    logic [IW-1:0]    tgt_idx;
    logic             ctrl_wr;
    logic             win_acc;

    assign ctrl_wr = (kind == ACC_CTRL) && bus_write;
    assign win_acc = (kind == ACC_WIN);

    burst_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_wr),
        .wdata  (bus_wdata),
        .cfg    (cfg),
        .rd_val (ctrl_rd)
    );

    burst_pos_counter u_pos (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (ctrl_wr),
        .win_acc  (win_acc),
        .len_code (cfg.len_code),
        .pos      (pos),
        .xfer_req (xfer_req)
    );

    burst_addr_map #(
        .AW        (AW),
        .IW        (IW),
        .NUM_REGS  (NUM_REGS),
        .CTRL_ADDR (CTRL_ADDR),
        .WIN_ADDR  (WIN_ADDR)
    ) u_map (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .base      (cfg.base),
        .pos       (pos),
        .kind      (kind),
        .tgt_ok    (tgt_ok),
        .tgt_idx   (tgt_idx)
    );

    assign reg_valid = tgt_ok;
    assign reg_write = tgt_ok & bus_write;
    assign reg_idx   = tgt_idx;
    assign reg_wdata = bus_wdata;

    always_comb begin
        case (kind)
            ACC_CTRL:            bus_rdata = ctrl_rd;
            ACC_WIN, ACC_DIRECT: bus_rdata = tgt_ok ? reg_rdata : '0;
            default:             bus_rdata = '0;
        endcase
    end

    // R7
    ext_range_chk: assert property (@(posedge clk) disable iff (rst)
        reg_valid |-> (int'(reg_idx) < NUM_REGS));

    // R9
    direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_DIRECT) |=> $stable(pos));

endmodule

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb;

    localparam int DW = 16, AW = 6, NREG = 20, CTRL = 20, WIN = 21, IW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, reg_wdata, reg_rdata;
    logic          reg_valid, reg_write, xfer_req;
    logic [IW-1:0] reg_idx;

    logic [DW-1:0] mem [32];
    int errors = 0, checks = 0;
    int m_base = 0, m_code = 0, m_pos = 0, m_active = 0, m_req = 0;

    always #2.5 clk = ~clk;

    assign reg_rdata = mem[reg_idx];

    burst_seq u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input int a,
                        input logic [DW-1:0] d, input string tag);
        int  tgt, n;
        bit  ev;
        logic [DW-1:0] erd;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = AW'(a); bus_wdata = d;
        #1;
        ev = 0; tgt = 0; erd = '0;
        if (v && a == CTRL) begin
            erd = DW'((m_code << 8) | m_base);
        end else if (v && a == WIN) begin
            tgt = m_base + m_pos;
            ev  = (tgt < NREG);
        end else if (v) begin
            tgt = a;
            ev  = (a < NREG);
        end
        if (ev) erd = mem[tgt];
        chk(reg_valid === ev, tag, "reg_valid", reg_valid, ev);
        if (ev) begin
            chk(reg_idx === IW'(tgt), tag, "reg_idx", reg_idx, tgt);
            chk(reg_write === w, tag, "reg_write", reg_write, w);
            if (w) chk(reg_wdata === d, tag, "reg_wdata", reg_wdata, d);
        end
        if (v && !w) chk(bus_rdata === erd, tag, "bus_rdata", bus_rdata, erd);
        chk(xfer_req === m_req[0], "R8", "xfer_req", xfer_req, m_req);
        @(posedge clk);
        if (ev && w) mem[tgt] = d;
        if (v && w && a == CTRL) begin
            m_base = d[4:0]; m_code = d[12:8]; m_pos = 0; m_active = 1; m_req = 1;
        end else if (v && a == WIN) begin
            n = ((m_code > 17) ? 17 : m_code) + 1;
            if (m_pos == n - 1) begin m_pos = 0; m_active = 0; end
            else m_pos++;
            m_req = 0;
        end else begin
            m_req = m_active;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = DW'(16'hA000 + i);
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        step(1, 0, CTRL, 0, "R1");
        step(1, 1, WIN, 16'h1111, "R1");
        step(1, 0, 0, 0, "R1");
        // R2 reserved bits ignored
        step(1, 1, CTRL, 16'hE6E0, "R2");
        step(1, 0, CTRL, 0, "R2");
        // R4 R10 seven reads with gaps, then wrap
        for (int i = 0; i < 7; i++) begin
            step(1, 0, WIN, 0, "R10");
            step(0, 0, 0, 0, "R8");
        end
        step(1, 0, WIN, 0, "R4");
        step(0, 0, 0, 0, "R8");
        // R5 R3 R7 clamp to 18, crossing end of file
        step(1, 1, CTRL, 16'h1F03, "R5");
        for (int i = 0; i < 18; i++) step(1, 1, WIN, DW'(16'h5000 + i), "R5");
        step(1, 1, WIN, 16'h7777, "R4");
        for (int i = 0; i < NREG; i++) step(1, 0, i, 0, "R3");
        // R7 fully out of range
        step(1, 1, CTRL, 16'h021F, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, WIN, 0, "R7");
        step(1, 1, WIN, 16'hDEAD, "R7");
        step(1, 0, 31, 0, "R7");
        // R6 control write mid burst
        step(1, 1, CTRL, 16'h0305, "R6");
        step(1, 0, WIN, 0, "R6");
        step(1, 0, WIN, 0, "R6");
        step(1, 1, CTRL, 16'h0305, "R6");
        step(1, 0, WIN, 0, "R6");
        // R9 direct accesses interleaved
        step(1, 1, 2, 16'h2222, "R9");
        step(1, 0, WIN, 0, "R9");
        step(1, 0, 2, 0, "R9");
        step(1, 0, WIN, 0, "R9");
        step(1, 0, WIN, 0, "R9");
        step(0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule